// File: doc/BRIEF.md
# Reflex Next-State Predictor

This block predicts the next sparse binary pattern in a stream, using only first-order context. It keeps a small associative table. Each valid row holds a stored pattern, the key, and a short list of the successors seen after that key, each with a hit count. On every accepted input the block searches all keys in parallel in the same cycle. When a key matches, the successor with the largest count is offered as the prediction for the next input.

In the same step, the row of the previous accepted input learns that the current input followed it. When the input does not match the prediction made one step earlier, the block raises a single-cycle anomaly pulse and advances a running miss count. Surrounding logic can use that count to decide when to hand the stream to a slower, higher-order sequence model.

Top module: `rm_reflex_predictor`

## Requirements
- R1: Each input taken with `in_valid` high gives exactly one result, with `out_valid` high on the next clock. `out_hit`, `out_pred_valid` and `out_anomaly` are low whenever `out_valid` is low. A cycle with `in_valid` low leaves the table, the previous-input context and the miss count unchanged.
- R2: `out_hit` is high when `in_sdr` equals the key of a valid row. If no row matches, the input is written as a new key into the row named by a round-robin pointer. The pointer starts at row 0 after reset and steps 0,1,…,ENTRIES-1, then wraps to 0, overwriting the old row and clearing its successors. `out_hit` is low for that step.
- R3: On a hit, `out_pred` is the successor with the highest count in the matching row, using the table as it stood before this step's learning. Among equal counts the lowest slot wins. If every count in the row is zero, `out_pred_valid` is low and `out_pred` is zero.
- R4: Every accepted input after the first is recorded as a successor of the previous accepted input's row. If that successor already sits in an occupied slot (count above zero), the slot's count rises by one.
- R5: A successor that is not yet present replaces the slot with the lowest count, with ties going to the lowest slot. Empty slots count as zero. The replacing slot starts at a count of 1.
- R6: Successor counts saturate at 2^CNT_W-1 and never wrap.
- R7: `out_anomaly` pulses together with a result when two conditions hold: the previous accepted step produced a valid prediction, and the current input differs from it. After a step without a prediction there is no anomaly.
- R8: `miss_count` rises by one in the same cycle as each `out_anomaly` pulse and holds otherwise. With MISS_SAT=1 it stops at its maximum value.
- R9: Reset empties the table, clears the pending prediction and the previous-input context, and drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sdr` for this cycle |
| in_sdr | input | SDR_W | Present-state pattern |
| out_valid | output | 1 | Result of the input taken one clock earlier |
| out_hit | output | 1 | That input matched a stored key |
| out_pred_valid | output | 1 | A successor prediction is available |
| out_pred | output | SDR_W | Predicted next pattern, zero when none |
| out_anomaly | output | 1 | Input differed from the previous prediction |
| miss_count | output | MISS_W | Running count of anomalies |

## Verification
Every result is registered once. Hit, prediction, anomaly and miss count for an input sampled at rising edge n are all visible after that edge and stay put until edge n+1. The bench drives inputs on the falling edge and samples all outputs at the next falling edge, half a clock after the capturing edge. Learning from step n first affects a prediction at the next accepted step, so the expected values in the vector table assume the table as it stood before each step's own update.

// File: rtl/rm_pkg.sv
package rm_pkg;

   // Action applied to one successor slot of the previous input's row
   typedef enum logic [1:0] {
      SLOT_HOLD = 2'd0,
      SLOT_BUMP = 2'd1,
      SLOT_LOAD = 2'd2
   } slot_op_e;

endpackage

// File: rtl/rm_key_match.sv
// Parallel key search over all rows; lowest matching row reported.
module rm_key_match #(
   parameter int N  = 8,
   parameter int W  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0][W-1:0] keys_i,
   input  logic [N-1:0]        vld_i,
   input  logic [W-1:0]        probe_i,
   output logic                hit_o,
   output logic [IW-1:0]       idx_o
);

   logic [N-1:0] eq;

   for (genvar e = 0; e < N; e++) begin : g_cmp
      assign eq[e] = vld_i[e] && (keys_i[e] == probe_i);
   end

   always_comb begin
      hit_o = |eq;
      idx_o = '0;
      for (int e = N - 1; e >= 0; e--) begin
         if (eq[e]) idx_o = IW'(e);
      end
   end

endmodule

// File: rtl/rm_slot_argmax.sv
// Highest-count slot of one row; strict compare keeps the lowest slot on ties.
module rm_slot_argmax #(
   parameter int S  = 4,
   parameter int KW = 16,
   parameter int CW = 8
) (
   input  logic [S-1:0][KW-1:0] skey_i,
   input  logic [S-1:0][CW-1:0] scnt_i,
   output logic [KW-1:0]        best_key_o,
   output logic [CW-1:0]        best_cnt_o
);

   always_comb begin
      best_key_o = skey_i[0];
      best_cnt_o = scnt_i[0];
      for (int s = 1; s < S; s++) begin
         if (scnt_i[s] > best_cnt_o) begin
            best_cnt_o = scnt_i[s];
            best_key_o = skey_i[s];
         end
      end
   end

endmodule

// File: rtl/rm_slot_locate.sv
// Finds an occupied slot holding the probe, and the lowest-count slot.
module rm_slot_locate #(
   parameter int S  = 4,
   parameter int KW = 16,
   parameter int CW = 8,
   localparam int SW = $clog2(S)
) (
   input  logic [S-1:0][KW-1:0] skey_i,
   input  logic [S-1:0][CW-1:0] scnt_i,
   input  logic [KW-1:0]        probe_i,
   output logic                 found_o,
   output logic [SW-1:0]        found_idx_o,
   output logic [SW-1:0]        low_idx_o
);

   logic [CW-1:0] low_cnt;

   always_comb begin
      found_o     = 1'b0;
      found_idx_o = '0;
      for (int s = S - 1; s >= 0; s--) begin
         if ((scnt_i[s] != '0) && (skey_i[s] == probe_i)) begin
            found_o     = 1'b1;
            found_idx_o = SW'(s);
         end
      end
      low_idx_o = '0;
      low_cnt   = scnt_i[0];
      for (int s = 1; s < S; s++) begin
         if (scnt_i[s] < low_cnt) begin
            low_cnt   = scnt_i[s];
            low_idx_o = SW'(s);
         end
      end
   end

endmodule

// File: rtl/rm_event_count.sv
// Event counter; SATURATE picks a clamping or wrapping variant.
module rm_event_count #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] count_o
);

   logic [W-1:0] nxt;

   if (SATURATE) begin : g_sat
      assign nxt = (count_o == '1) ? count_o : count_o + W'(1);
   end else begin : g_wrap
      assign nxt = count_o + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_o <= '0;
      else if (inc_i) count_o <= nxt;
   end

endmodule

// File: rtl/rm_reflex_predictor.sv
module rm_reflex_predictor
   import rm_pkg::*;
#(
   parameter int SDR_W    = 16,
   parameter int ENTRIES  = 8,
   parameter int SLOTS    = 4,
   parameter int CNT_W    = 8,
   parameter int MISS_W   = 16,
   parameter bit MISS_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SDR_W-1:0]  in_sdr,
   output logic              out_valid,
   output logic              out_hit,
   output logic              out_pred_valid,
   output logic [SDR_W-1:0]  out_pred,
   output logic              out_anomaly,
   output logic [MISS_W-1:0] miss_count
);

   localparam int IDX_W  = $clog2(ENTRIES);
   localparam int SIDX_W = $clog2(SLOTS);

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (SDR_W < 1 || MISS_W < 1) begin : g_bad_width
      $error("SDR_W and MISS_W must be positive");
   end

   // table storage
   logic [ENTRIES-1:0][SDR_W-1:0]            key_q;
   logic [ENTRIES-1:0]                       ent_vld_q;
   logic [ENTRIES-1:0][SLOTS-1:0][SDR_W-1:0] skey_q;
   logic [ENTRIES-1:0][SLOTS-1:0][CNT_W-1:0] scnt_q;
   logic [IDX_W-1:0]                         rr_q;

   // context
   logic [IDX_W-1:0] prev_idx_q;
   logic             prev_vld_q;
   logic             pend_vld_q;
   logic [SDR_W-1:0] pend_q;

   // output registers
   logic             out_valid_q, out_hit_q, out_pv_q, out_anom_q;
   logic [SDR_W-1:0] out_pred_q;

   // lookup of the present input
   logic             look_hit;
   logic [IDX_W-1:0] look_idx;
   logic [SDR_W-1:0] best_key;
   logic [CNT_W-1:0] best_cnt;
   logic             look_pv;

   rm_key_match #(.N(ENTRIES), .W(SDR_W)) u_match (
      .keys_i  (key_q),
      .vld_i   (ent_vld_q),
      .probe_i (in_sdr),
      .hit_o   (look_hit),
      .idx_o   (look_idx)
   );

   rm_slot_argmax #(.S(SLOTS), .KW(SDR_W), .CW(CNT_W)) u_argmax (
      .skey_i     (skey_q[look_idx]),
      .scnt_i     (scnt_q[look_idx]),
      .best_key_o (best_key),
      .best_cnt_o (best_cnt)
   );

   assign look_pv = look_hit && (best_cnt != '0);

   // learning on the previous input's row
   logic              fnd;
   logic [SIDX_W-1:0] fnd_idx;
   logic [SIDX_W-1:0] low_idx;
   logic [CNT_W-1:0]  cur_cnt;
   logic [CNT_W-1:0]  bumped;
   slot_op_e          upd_op;

   rm_slot_locate #(.S(SLOTS), .KW(SDR_W), .CW(CNT_W)) u_locate (
      .skey_i      (skey_q[prev_idx_q]),
      .scnt_i      (scnt_q[prev_idx_q]),
      .probe_i     (in_sdr),
      .found_o     (fnd),
      .found_idx_o (fnd_idx),
      .low_idx_o   (low_idx)
   );

   always_comb begin
      cur_cnt = scnt_q[prev_idx_q][fnd_idx];
      bumped  = (cur_cnt == '1) ? cur_cnt : cur_cnt + CNT_W'(1);
      if (in_valid && prev_vld_q) upd_op = fnd ? SLOT_BUMP : SLOT_LOAD;
      else                        upd_op = SLOT_HOLD;
   end

   logic step_anom;
   assign step_anom = in_valid && pend_vld_q && (in_sdr != pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q       <= '0;
         ent_vld_q   <= '0;
         skey_q      <= '0;
         scnt_q      <= '0;
         rr_q        <= '0;
         prev_idx_q  <= '0;
         prev_vld_q  <= 1'b0;
         pend_vld_q  <= 1'b0;
         pend_q      <= '0;
         out_valid_q <= 1'b0;
         out_hit_q   <= 1'b0;
         out_pv_q    <= 1'b0;
         out_pred_q  <= '0;
         out_anom_q  <= 1'b0;
      end else begin
         out_valid_q <= in_valid;
         out_hit_q   <= in_valid && look_hit;
         out_pv_q    <= in_valid && look_pv;
         out_pred_q  <= (in_valid && look_pv) ? best_key : '0;
         out_anom_q  <= step_anom;
         if (in_valid) begin
            pend_vld_q <= look_pv;
            pend_q     <= best_key;
            prev_vld_q <= 1'b1;
            prev_idx_q <= look_hit ? look_idx : rr_q;
            case (upd_op)
               SLOT_BUMP: scnt_q[prev_idx_q][fnd_idx] <= bumped;
               SLOT_LOAD: begin
                  skey_q[prev_idx_q][low_idx] <= in_sdr;
                  scnt_q[prev_idx_q][low_idx] <= CNT_W'(1);
               end
               default: ;
            endcase
            // allocation is written last so it wins over learning on the same row
            if (!look_hit) begin
               key_q[rr_q]     <= in_sdr;
               ent_vld_q[rr_q] <= 1'b1;
               skey_q[rr_q]    <= '0;
               scnt_q[rr_q]    <= '0;
               rr_q            <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
            end
         end
      end
   end

   rm_event_count #(.W(MISS_W), .SATURATE(MISS_SAT)) u_miss (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (step_anom),
      .count_o (miss_count)
   );

   assign out_valid      = out_valid_q;
   assign out_hit        = out_hit_q;
   assign out_pred_valid = out_pv_q;
   assign out_pred       = out_pred_q;
   assign out_anomaly    = out_anom_q;

endmodule

// File: rtl/rm_reflex_checks.sv
module rm_reflex_checks #(
   parameter int SDR_W  = 16,
   parameter int MISS_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [SDR_W-1:0]  in_sdr,
   input logic              out_valid,
   input logic              out_hit,
   input logic              out_pred_valid,
   input logic [SDR_W-1:0]  out_pred,
   input logic              out_anomaly,
   input logic [MISS_W-1:0] miss_count
);

   // last prediction seen at the outputs
   logic             seen_pv;
   logic [SDR_W-1:0] seen_pred;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_pv   <= 1'b0;
         seen_pred <= '0;
      end else if (out_valid) begin
         seen_pv   <= out_pred_valid;
         seen_pred <= out_pred;
      end
   end

   p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_spurious_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_flags_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_hit && !out_pred_valid && !out_anomaly));

   p_pred_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_pred_valid |-> out_hit);

   p_anomaly_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_anomaly == (seen_pv && ($past(in_sdr) != seen_pred))));

   p_miss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_anomaly |-> $stable(miss_count));

   p_miss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_anomaly && ($past(miss_count) != '1)) |->
         (miss_count == MISS_W'($past(miss_count) + MISS_W'(1))));

endmodule

bind rm_reflex_predictor rm_reflex_checks #(.SDR_W(SDR_W), .MISS_W(MISS_W)) u_checks (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .in_sdr         (in_sdr),
   .out_valid      (out_valid),
   .out_hit        (out_hit),
   .out_pred_valid (out_pred_valid),
   .out_pred       (out_pred),
   .out_anomaly    (out_anomaly),
   .miss_count     (miss_count)
);

// File: tb/tb_rm_reflex_predictor.sv
module tb_rm_reflex_predictor;

   localparam int CLK_PERIOD = 10;
   localparam int SW = 16;
   localparam int MW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_sdr = '0;
   logic          out_valid, out_hit, out_pred_valid, out_anomaly;
   logic [SW-1:0] out_pred;
   logic [MW-1:0] miss_count;

   int total = 0;
   int bad = 0;

   rm_reflex_predictor dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sdr(in_sdr),
      .out_valid(out_valid), .out_hit(out_hit), .out_pred_valid(out_pred_valid),
      .out_pred(out_pred), .out_anomaly(out_anomaly), .miss_count(miss_count)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct packed {
      logic          v;
      logic [SW-1:0] sdr;
      logic          hit;
      logic          pv;
      logic [SW-1:0] pred;
      logic          anom;
      logic [MW-1:0] miss;
   } vec_t;

   // A=0011 B=0022 C=0044; row 5 is an idle cycle carrying junk
   localparam vec_t VEC [11] = '{
      '{1'b1, 16'h0011, 1'b0, 1'b0, 16'h0000, 1'b0, 16'd0},
      '{1'b1, 16'h0022, 1'b0, 1'b0, 16'h0000, 1'b0, 16'd0},
      '{1'b1, 16'h0011, 1'b1, 1'b1, 16'h0022, 1'b0, 16'd0},
      '{1'b1, 16'h0022, 1'b1, 1'b1, 16'h0011, 1'b0, 16'd0},
      '{1'b0, 16'hDEAD, 1'b0, 1'b0, 16'h0000, 1'b0, 16'd0},
      '{1'b1, 16'h0044, 1'b0, 1'b0, 16'h0000, 1'b1, 16'd1},
      '{1'b1, 16'h0022, 1'b1, 1'b1, 16'h0011, 1'b0, 16'd1},
      '{1'b1, 16'h0044, 1'b1, 1'b1, 16'h0022, 1'b1, 16'd2},
      '{1'b1, 16'h0022, 1'b1, 1'b1, 16'h0044, 1'b0, 16'd2},
      '{1'b1, 16'h0011, 1'b1, 1'b1, 16'h0022, 1'b1, 16'd3},
      '{1'b1, 16'h0022, 1'b1, 1'b1, 16'h0011, 1'b0, 16'd3}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive on a falling edge, result sampled at the next falling edge
   task automatic step(input logic v, input logic [SW-1:0] s);
      in_valid = v;
      in_sdr   = s;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n    = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      do_reset();
      // R9: reset state at the ports
      chk("R9", "out_valid", 32'(out_valid), 0);
      chk("R9", "out_pred", 32'(out_pred), 0);
      chk("R9", "miss_count", 32'(miss_count), 0);
      chk("R9", "flags", {29'd0, out_hit, out_pred_valid, out_anomaly}, 0);

      // vector walk: R1 R2 R3 R4 R5 R7 R8
      for (int i = 0; i < 11; i++) begin
         step(VEC[i].v, VEC[i].sdr);
         chk("R1", $sformatf("row%0d out_valid", i), 32'(out_valid), 32'(VEC[i].v));
         chk("R2", $sformatf("row%0d out_hit", i), 32'(out_hit), 32'(VEC[i].hit));
         chk("R3", $sformatf("row%0d out_pred_valid", i), 32'(out_pred_valid), 32'(VEC[i].pv));
         chk("R3", $sformatf("row%0d out_pred", i), 32'(out_pred), 32'(VEC[i].pred));
         chk("R7", $sformatf("row%0d out_anomaly", i), 32'(out_anomaly), 32'(VEC[i].anom));
         chk("R8", $sformatf("row%0d miss_count", i), 32'(miss_count), 32'(VEC[i].miss));
      end

      // R3: fresh row without successors, then a self-loop
      do_reset();
      step(1'b1, 16'h0500);
      step(1'b1, 16'h0500);
      chk("R3", "empty row hit", 32'(out_hit), 1);
      chk("R3", "empty row pred_valid", 32'(out_pred_valid), 0);
      chk("R3", "empty row pred", 32'(out_pred), 0);
      step(1'b1, 16'h0500);
      chk("R4", "self successor pred", 32'(out_pred), 32'h0500);
      chk("R7", "no anomaly after no prediction", 32'(out_anomaly), 0);

      // R5: X row gets A2 B1 C2 D1, then E evicts slot 1 (B) at count 1
      do_reset();
      step(1'b1, 16'h0A00); step(1'b1, 16'h0A01);
      step(1'b1, 16'h0A00); step(1'b1, 16'h0A01);
      step(1'b1, 16'h0A00); step(1'b1, 16'h0A02);
      step(1'b1, 16'h0A00); step(1'b1, 16'h0A03);
      step(1'b1, 16'h0A00); step(1'b1, 16'h0A03);
      step(1'b1, 16'h0A00); step(1'b1, 16'h0A04);
      step(1'b1, 16'h0A00); step(1'b1, 16'h0A05);
      step(1'b1, 16'h0A00);
      chk("R5", "after insert pred", 32'(out_pred), 32'h0A01);
      step(1'b1, 16'h0A05);
      step(1'b1, 16'h0A00);
      chk("R5", "new slot at 2 ties low slot", 32'(out_pred), 32'h0A01);
      step(1'b1, 16'h0A05);
      step(1'b1, 16'h0A00);
      chk("R4", "inserted slot counts up", 32'(out_pred), 32'h0A05);

      // R6: 256 P->Q follows saturate at 255, then R seen twice
      do_reset();
      for (int k = 0; k < 256; k++) begin
         step(1'b1, 16'h0B01);
         step(1'b1, 16'h0B02);
      end
      step(1'b1, 16'h0B01); step(1'b1, 16'h0B03);
      step(1'b1, 16'h0B01); step(1'b1, 16'h0B03);
      step(1'b1, 16'h0B01);
      chk("R6", "saturated slot still wins", 32'(out_pred), 32'h0B02);

      // R2: nine distinct keys over eight rows, row 0 is reused
      do_reset();
      for (int k = 0; k < 9; k++) begin
         step(1'b1, 16'(16'h0100 + k));
         chk("R2", $sformatf("fill key %0d misses", k), 32'(out_hit), 0);
      end
      step(1'b1, 16'h0101);
      chk("R2", "row 1 survives", 32'(out_hit), 1);
      chk("R3", "row 1 successor", 32'(out_pred), 32'h0102);
      step(1'b1, 16'h0100);
      chk("R2", "row 0 evicted", 32'(out_hit), 0);
      chk("R7", "mismatch flagged", 32'(out_anomaly), 1);
      chk("R8", "miss count one", 32'(miss_count), 1);

      // R9: reset clears table and context mid-run
      do_reset();
      chk("R9", "miss cleared", 32'(miss_count), 0);
      step(1'b1, 16'h0101);
      chk("R9", "table empty after reset", 32'(out_hit), 0);
      chk("R9", "no pending prediction", 32'(out_anomaly), 0);
      step(1'b0, 16'h0000);
      chk("R1", "idle gives no result", 32'(out_valid), 0);

      summary();
      $finish;
   end

endmodule